// File: doc/BRIEF.md
# Pattern Memory Bank Translator

This block turns a 13-bit video pattern address into a physical pattern-memory address. The 8 KiB video space is split into eight 1 KiB windows. The top three address bits pick a window, and the block replaces them with a physical 1 KiB bank number. The low ten bits pass through unchanged. The bank number comes from stable configuration inputs: a mode/size control byte, an outer bank byte, a latch-enable byte, a two-bit discrete latch, a half-swap flag, an extended-mode flag and twelve inner bank registers. Register writes happen outside this block, and so do any counters.

Three banking schemes are available.
- **Discrete-latch scheme:** eight consecutive banks are taken from an 8-bank aligned base. The two-bit latch can widen that base, but only when it is enabled.
- **Normal inner-register scheme:** two 2 KiB pairs and four single 1 KiB windows, each subject to a size-dependent mask.
- **Extended inner-register scheme:** eight independently chosen 1 KiB banks.

Both inner-register schemes OR the outer bank into the result, and both can swap the two 4 KiB halves. The translated address is registered once, so it appears one clock after the video address.

Top module: `pmbt_translator`

## Requirements
- R1: While `rst_n` is low, `bank_o` and `phys_addr_o` are zero.
- R2: `phys_addr_o` equals {bank, vaddr[9:0]} for the `vaddr` and configuration sampled at the previous rising clock edge. `bank_o` is the same bank number.
- R3: The discrete-latch scheme is selected when bit 6 of `mode_cfg` is 1. The low three bank bits then equal vaddr[12:10], and `swap_halves` has no effect.
- R4: In the discrete-latch scheme the latch mask is 0 when `latch_cfg` AND 0x46 is zero. Otherwise it is 0x1 if bit 4 of `mode_cfg` is 1, and 0x3 if that bit is 0.
- R5: In the discrete-latch scheme bank[10:3] = `outer_bank` OR (`latch_val` AND mask).
- R6: In both inner-register schemes, when `swap_halves` is 1 the register slot is vaddr[12:10] XOR 4.
- R7: In both inner-register schemes, the bank equals the slot's register value ORed with `outer_bank` shifted left by 3.
- R8: In the normal scheme the register value is masked with 0x7F when bit 4 of `mode_cfg` is 1, and with 0xFF when it is 0.
- R9: In the normal scheme, slots 0 and 1 use masked inner register 0, with bit 0 forced to 0 and to 1 respectively. Slots 2 and 3 do the same with inner register 1.
- R10: In the normal scheme, slots 4 to 7 use masked inner registers 2, 3, 4 and 5.
- R11: The extended scheme is selected when `ext_mode` is 1 and bit 6 of `mode_cfg` is 0. It applies no mask, and slots 0 to 7 use inner registers 0, 10, 1, 11, 2, 3, 4, 5.
- R12: When bit 6 of `mode_cfg` is 1, the discrete-latch scheme is used whatever the value of `ext_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | 8 | Mode/size control byte (bit 6 latch scheme, bit 4 small outer size) |
| outer_bank | input | 8 | Outer bank number in 8 KiB units |
| latch_cfg | input | 8 | Latch-enable byte (bits 0x46) |
| latch_val | input | 2 | Discrete bank latch |
| swap_halves | input | 1 | Swap the two 4 KiB halves in the inner-register schemes |
| ext_mode | input | 1 | Select the extended inner-register scheme |
| inner_banks | input | 96 | Twelve 8-bit inner bank registers, register i at bits [8i+7:8i] |
| vaddr | input | 13 | Video pattern address |
| bank_o | output | 11 | Registered physical 1 KiB bank number |
| phys_addr_o | output | 21 | Registered physical address {bank, vaddr[9:0]} |

## Verification
The situation hardest to reach from the ports is the discrete-latch contribution: it only shows when bits 0x46 of the latch-enable byte are set, and it is clipped to one bit by the size control. The outer bank's low bits can also hide it. The stimulus therefore holds `outer_bank` with zero low bits, sets each enable bit alone, toggles the size bit and steps the latch through every value. The normal scheme's forced-low bit is also awkward, because it disappears when the register value is already even. Odd register values are used there, together with the half swap, so that every pair window shows the forced bit.

// File: rtl/pmbt_pkg.sv
package pmbt_pkg;
    localparam int SLOT_W        = 3;
    localparam int CFG_LATCH_BIT = 6;
    localparam int CFG_SIZE_BIT  = 4;
    localparam logic [7:0] LATCH_EN_BITS = 8'h46;

    typedef enum logic [1:0] {
        XM_NORMAL = 2'd0,
        XM_EXT    = 2'd1,
        XM_LATCH  = 2'd2
    } xmode_e;
endpackage

// File: rtl/pmbt_slot_map.sv
module pmbt_slot_map
    import pmbt_pkg::*;
(
    input  logic [SLOT_W-1:0] win,
    input  logic              swap,
    input  logic              latch_mode,
    output logic [SLOT_W-1:0] slot
);
    // halves swap only for the register-driven schemes
    logic flip;
    assign flip = swap & ~latch_mode;
    assign slot = win ^ {flip, {(SLOT_W-1){1'b0}}};
endmodule

// File: rtl/pmbt_latch_bank.sv
module pmbt_latch_bank
    import pmbt_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic [REG_W-1:0]        latch_cfg,
    input  logic                    small_size,
    input  logic [REG_W-1:0]        outer_bank,
    input  logic [1:0]              latch_val,
    input  logic [SLOT_W-1:0]       slot,
    output logic [REG_W+SLOT_W-1:0] bank
);
    localparam logic [REG_W-1:0] EN_BITS = REG_W'(LATCH_EN_BITS);

    logic             latch_on;
    logic [1:0]       lmask;
    logic [REG_W-1:0] base;

    assign latch_on = |(latch_cfg & EN_BITS);

    always_comb begin
        lmask = 2'b00;
        if (latch_on) begin
            lmask = small_size ? 2'b01 : 2'b11;
        end
    end

    assign base = outer_bank | {{(REG_W-2){1'b0}}, latch_val & lmask};
    assign bank = {base, slot};
endmodule

// File: rtl/pmbt_inner_bank.sv
module pmbt_inner_bank
    import pmbt_pkg::*;
#(
    parameter int REG_W     = 8,
    parameter int NUM_INNER = 12
) (
    input  logic [NUM_INNER*REG_W-1:0] inner_banks,
    input  logic                       small_size,
    input  logic                       ext_sel,
    input  logic [REG_W-1:0]           outer_bank,
    input  logic [SLOT_W-1:0]          slot,
    output logic [REG_W+SLOT_W-1:0]    bank
);
    localparam int NUM_SLOTS = 1 << SLOT_W;

    // register feeding each slot in the extended scheme
    function automatic int ext_src(input int g);
        case (g)
            0:       return 0;
            1:       return 10;
            2:       return 1;
            3:       return 11;
            default: return g - 2;
        endcase
    endfunction

    logic [REG_W-1:0] ireg     [NUM_INNER];
    logic [REG_W-1:0] norm_tab [NUM_SLOTS];
    logic [REG_W-1:0] ext_tab  [NUM_SLOTS];
    logic [REG_W-1:0] imask;
    logic [REG_W-1:0] pick;

    for (genvar i = 0; i < NUM_INNER; i++) begin : g_unpack
        assign ireg[i] = inner_banks[i*REG_W +: REG_W];
    end

    assign imask = small_size ? {1'b0, {(REG_W-1){1'b1}}} : {REG_W{1'b1}};

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam int EIDX = ext_src(g);
        logic [REG_W-1:0] masked;
        if (g < 4) begin : g_pair
            localparam logic LOWB = (g % 2) != 0;
            assign masked      = ireg[g/2] & imask;
            assign norm_tab[g] = {masked[REG_W-1:1], LOWB};
        end else begin : g_single
            assign masked      = ireg[g-2] & imask;
            assign norm_tab[g] = masked;
        end
        assign ext_tab[g] = ireg[EIDX];
    end

    assign pick = ext_sel ? ext_tab[slot] : norm_tab[slot];
    assign bank = {{SLOT_W{1'b0}}, pick} | {outer_bank, {SLOT_W{1'b0}}};
endmodule

// File: rtl/pmbt_translator.sv
module pmbt_translator
    import pmbt_pkg::*;
#(
    parameter int REG_W     = 8,
    parameter int WIN_BITS  = 10,
    parameter int NUM_INNER = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [REG_W-1:0]                    mode_cfg,
    input  logic [REG_W-1:0]                    outer_bank,
    input  logic [REG_W-1:0]                    latch_cfg,
    input  logic [1:0]                          latch_val,
    input  logic                                swap_halves,
    input  logic                                ext_mode,
    input  logic [NUM_INNER*REG_W-1:0]          inner_banks,
    input  logic [WIN_BITS+SLOT_W-1:0]          vaddr,
    output logic [REG_W+SLOT_W-1:0]             bank_o,
    output logic [REG_W+SLOT_W+WIN_BITS-1:0]    phys_addr_o
);
    localparam int BANK_W  = REG_W + SLOT_W;
    localparam int VADDR_W = WIN_BITS + SLOT_W;

    typedef struct packed {
        logic [BANK_W-1:0]   bank;
        logic [WIN_BITS-1:0] offs;
    } xlat_t;

    xlat_t             st_d, st_q;
    xmode_e            mode_sel;
    logic              latch_mode;
    logic              small_size;
    logic [SLOT_W-1:0] slot;
    logic [BANK_W-1:0] latch_bank;
    logic [BANK_W-1:0] inner_bank;
    logic              unused_cfg;

    assign latch_mode = mode_cfg[CFG_LATCH_BIT];
    assign small_size = mode_cfg[CFG_SIZE_BIT];
    assign unused_cfg = ^mode_cfg;

    always_comb begin
        if (latch_mode)    mode_sel = XM_LATCH;
        else if (ext_mode) mode_sel = XM_EXT;
        else               mode_sel = XM_NORMAL;
    end

    pmbt_slot_map u_slot (
        .win        (vaddr[VADDR_W-1:WIN_BITS]),
        .swap       (swap_halves),
        .latch_mode (latch_mode),
        .slot       (slot)
    );

    pmbt_latch_bank #(.REG_W(REG_W)) u_latch (
        .latch_cfg  (latch_cfg),
        .small_size (small_size),
        .outer_bank (outer_bank),
        .latch_val  (latch_val),
        .slot       (slot),
        .bank       (latch_bank)
    );

    pmbt_inner_bank #(.REG_W(REG_W), .NUM_INNER(NUM_INNER)) u_inner (
        .inner_banks (inner_banks),
        .small_size  (small_size),
        .ext_sel     (mode_sel == XM_EXT),
        .outer_bank  (outer_bank),
        .slot        (slot),
        .bank        (inner_bank)
    );

    always_comb begin
        st_d      = st_q;
        st_d.offs = vaddr[WIN_BITS-1:0];
        case (mode_sel)
            XM_LATCH: st_d.bank = latch_bank;
            default:  st_d.bank = inner_bank;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_o      = st_q.bank;
    assign phys_addr_o = st_q;
endmodule

// File: rtl/pmbt_checker.sv
module pmbt_checker
    import pmbt_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int WIN_BITS = 10
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [REG_W-1:0]                 mode_cfg,
    input logic [REG_W-1:0]                 outer_bank,
    input logic [REG_W-1:0]                 latch_cfg,
    input logic                             ext_mode,
    input logic [WIN_BITS+SLOT_W-1:0]       vaddr,
    input logic [REG_W+SLOT_W-1:0]          bank_o,
    input logic [REG_W+SLOT_W+WIN_BITS-1:0] phys_addr_o
);
    localparam logic [REG_W-1:0] EN_BITS = REG_W'(LATCH_EN_BITS);
    localparam int BANK_W = REG_W + SLOT_W;

    logic latch_mode, small_size, normal_mode, unused_chk;
    assign latch_mode  = mode_cfg[CFG_LATCH_BIT];
    assign small_size  = mode_cfg[CFG_SIZE_BIT];
    assign normal_mode = !latch_mode && !ext_mode;
    assign unused_chk  = ^mode_cfg;

    a_r2_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phys_addr_o[WIN_BITS-1:0] == $past(vaddr[WIN_BITS-1:0])
                  && phys_addr_o[BANK_W+WIN_BITS-1:WIN_BITS] == bank_o));

    a_r3_latch_window: assert property (@(posedge clk) disable iff (!rst_n)
        latch_mode |=> bank_o[SLOT_W-1:0] == $past(vaddr[WIN_BITS+SLOT_W-1:WIN_BITS]));

    a_r4_latch_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && (latch_cfg & EN_BITS) == '0)
        |=> bank_o[BANK_W-1:SLOT_W] == $past(outer_bank));

    a_r7_outer_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_mode |=> (bank_o & {$past(outer_bank), {SLOT_W{1'b0}}})
                        == {$past(outer_bank), {SLOT_W{1'b0}}});

    a_r8_small_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_mode && small_size && outer_bank == '0) |=> !bank_o[REG_W-1]);
endmodule

bind pmbt_translator pmbt_checker #(.REG_W(REG_W), .WIN_BITS(WIN_BITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_cfg    (mode_cfg),
    .outer_bank  (outer_bank),
    .latch_cfg   (latch_cfg),
    .ext_mode    (ext_mode),
    .vaddr       (vaddr),
    .bank_o      (bank_o),
    .phys_addr_o (phys_addr_o)
);

// File: tb/pmbt_translator_tb_top.sv
`timescale 1ns/1ps
module pmbt_translator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mcfg = 8'h00;
    logic [7:0]  outer = 8'h00;
    logic [7:0]  lcfg = 8'h00;
    logic [1:0]  lat = 2'b00;
    logic        swp = 1'b0;
    logic        ext = 1'b0;
    logic [12:0] va = 13'h0;
    logic [7:0]  ireg [12];
    logic [95:0] inner_flat;
    logic [10:0] bank;
    logic [20:0] phys;
    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 12; i++) inner_flat[i*8 +: 8] = ireg[i];
    end

    pmbt_translator dut_i (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mcfg), .outer_bank(outer),
        .latch_cfg(lcfg), .latch_val(lat), .swap_halves(swp), .ext_mode(ext),
        .inner_banks(inner_flat), .vaddr(va), .bank_o(bank), .phys_addr_o(phys)
    );

    // expected bank, built from the requirement text
    function automatic logic [10:0] model_bank(input logic [12:0] a);
        logic [2:0] s;
        logic [1:0] lm;
        logic [7:0] v, m;
        s = a[12:10];
        if (mcfg[6]) begin                              // R3, R12
            lm = ((lcfg & 8'h46) != 0) ? (mcfg[4] ? 2'b01 : 2'b11) : 2'b00; // R4
            return {outer | {6'b0, lat & lm}, s};       // R5
        end
        if (swp) s = s ^ 3'd4;                          // R6
        if (ext) begin                                  // R11
            case (s)
                3'd0: v = ireg[0];
                3'd1: v = ireg[10];
                3'd2: v = ireg[1];
                3'd3: v = ireg[11];
                default: v = ireg[int'(s) - 2];
            endcase
        end else begin
            m = mcfg[4] ? 8'h7F : 8'hFF;                // R8
            if (s < 3'd4) begin                         // R9
                v = ireg[int'(s) / 2] & m;
                v[0] = s[0];
            end else begin
                v = ireg[int'(s) - 2] & m;              // R10
            end
        end
        return {3'b000, v} | {outer, 3'b000};           // R7
    endfunction

    task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [12:0] a);
        @(negedge clk);
        va = a;
        @(posedge clk);
        #1;
        check(req, phys, {model_bank(a), a[9:0]});
        check(req, {10'b0, bank}, {10'b0, model_bank(a)});
    endtask

    task automatic all_windows(input string req, input logic [9:0] off);
        for (int w = 0; w < 8; w++) probe(req, {w[2:0], off});
    endtask

    task automatic t_reset;
        mcfg = 8'h40; outer = 8'hA5; va = 13'h1FFF;
        @(posedge clk); @(posedge clk); #1;
        check("R1", phys, 21'h0);
        check("R1", {10'b0, bank}, 21'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_offset_latency;
        mcfg = 8'h00; ext = 1'b0; swp = 1'b0; outer = 8'h00;
        probe("R2", 13'h0155);
        probe("R2", 13'h1BFF);
        @(negedge clk); va = 13'h0000;
        #1;
        check("R2", phys, {model_bank(13'h1BFF), 10'h3FF});   // unchanged before the edge
        @(posedge clk); #1;
        check("R2", phys, {model_bank(13'h0000), 10'h000});
    endtask

    task automatic t_latch_mode;
        mcfg = 8'h40; outer = 8'h30; lat = 2'b11; swp = 1'b1;
        lcfg = 8'h00; all_windows("R4", 10'h012);         // mask zero, swap ignored (R3)
        lcfg = 8'h02; all_windows("R5", 10'h3A0);         // full mask
        lcfg = 8'h04; mcfg = 8'h50; all_windows("R4", 10'h001); // one-bit mask
        lcfg = 8'h40; mcfg = 8'h40;
        for (int l = 0; l < 4; l++) begin
            lat = l[1:0];
            probe("R5", 13'h0C00);
        end
        lcfg = 8'hB9; probe("R4", 13'h1400);              // only non-enable bits set
        ext = 1'b1; lcfg = 8'h46; probe("R12", 13'h0800); probe("R12", 13'h1C00);
        ext = 1'b0; swp = 1'b0;
    endtask

    task automatic t_normal;
        mcfg = 8'h00; ext = 1'b0; swp = 1'b0; outer = 8'h00;
        ireg[0] = 8'hF1; ireg[1] = 8'h83; ireg[2] = 8'hC4;
        ireg[3] = 8'h95; ireg[4] = 8'h86; ireg[5] = 8'hFF;
        all_windows("R9", 10'h0AB);
        mcfg = 8'h10; all_windows("R8", 10'h2CC);
        swp = 1'b1; all_windows("R6", 10'h3FF);
        outer = 8'h1C; mcfg = 8'h00; all_windows("R7", 10'h111);
        swp = 1'b0; ireg[2] = 8'h00; ireg[5] = 8'h7E; all_windows("R10", 10'h000);
    endtask

    task automatic t_extended;
        mcfg = 8'h10; ext = 1'b1; swp = 1'b0; outer = 8'h00;
        ireg[0] = 8'hF1; ireg[10] = 8'hAB; ireg[1] = 8'h83; ireg[11] = 8'hCD;
        ireg[2] = 8'hE2; ireg[3] = 8'h93; ireg[4] = 8'h84; ireg[5] = 8'hF5;
        all_windows("R11", 10'h155);
        swp = 1'b1; outer = 8'h21; all_windows("R6", 10'h2AA);
        ext = 1'b0; swp = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 12; i++) ireg[i] = 8'(i * 17 + 3);
        t_reset();
        t_offset_latency();
        t_latch_mode();
        t_normal();
        t_extended();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule